// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors that live in system memory. A single-cycle poll request starts the walk, and only while transmission is enabled. Each descriptor takes 16 bytes and holds four words. Word 0 is a control/status word. Word 1 packs two buffer size fields: buffer 1 in bits 15:0 and buffer 2 in bits 31:16. Word 2 is the buffer 1 byte address, and word 3 is a second address that the engine reads and then discards.

For every descriptor the engine owns, it does the following:
- fetches the four words through a word-wide read port;
- copies the segment bytes into an internal frame store;
- writes the control word back with the ownership flag cleared;
- moves its current pointer forward by one descriptor, or back to the ring base.

When a descriptor marks the end of a frame, the engine sends out the whole frame as a byte stream and raises a completion pulse and a summary pulse. A frame too large for the store is discarded and reported instead. The engine also flags size fields it does not support.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset the current descriptor pointer is 0, and no memory request, write or stream beat is active.
- R2: A poll request with transmission enabled starts a walk. It reads the four words at the current pointer (offsets 0, 4, 8, 12) in ascending order. A poll request with transmission disabled has no effect.
- R3: If bit 31 (ownership) of a fetched control word is 0, the walk stops. That descriptor is not written back, the pointer keeps its value, and no pulse is raised.
- R4: The segment length is word 1 bits 11:0 plus word 1 bits 27:16. The bytes are read starting at the byte address in word 2. The byte at address a sits in bits 8*a[1:0]+7 down to 8*a[1:0] of the word at a with its low two bits cleared.
- R5: Segments accumulate until a descriptor with bit 29 (last segment) set. The frame is then sent as one byte per cycle on txValid/txData, with txLast on the final byte only, and txDonePulse and summaryPulse each pulse once.
- R6: Every owned descriptor has its control word written back to the descriptor's own address, with bit 31 cleared and all other bits unchanged.
- R7: After write-back, the pointer loads the ring base if bit 21 (wrap) of the control word is set. Otherwise it advances by 16.
- R8: A buffer 1 length above 2048 or a nonzero buffer 2 length raises sizeErrPulse, and processing of the descriptor continues.
- R9: If the frame length so far plus the segment length reaches FRAME_BYTES, dropErrPulse is raised once. That frame's remaining segments are written back but not copied, and the frame produces no bytes and no completion pulse.
- R10: After a descriptor is finished, the walk goes on to the next descriptor if transmission is still enabled. Otherwise it stops before any further read.
- R11: A base-load strobe sets both the ring base and the current pointer to ringBase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmission enable |
| pollDemand | input | 1 | Single-cycle request to start a walk |
| ringBaseWr | input | 1 | Load strobe for ring base and current pointer |
| ringBase | input | AW | Ring base byte address |
| curDescAddr | output | AW | Current descriptor pointer |
| memRdReq | output | 1 | Single-cycle read request |
| memRdAddr | output | AW | Word-aligned read byte address |
| memRdValid | input | 1 | Read data valid, one or more cycles after the request |
| memRdData | input | 32 | Read data |
| memWrEn | output | 1 | Descriptor write-back strobe |
| memWrAddr | output | AW | Write-back byte address |
| memWrData | output | 32 | Write-back control word |
| txData | output | 8 | Frame byte |
| txValid | output | 1 | Frame byte valid |
| txLast | output | 1 | Final byte of a frame |
| txDonePulse | output | 1 | Frame sent |
| summaryPulse | output | 1 | Normal summary status |
| sizeErrPulse | output | 1 | Unsupported size field seen |
| dropErrPulse | output | 1 | Frame dropped for capacity |

## Verification
The bench builds the engine with AW = 16 and FRAME_BYTES = 64. With a 64-byte store, a frame of 63 bytes, a frame of exactly 64 bytes and a two-segment frame that overflows can all be set up in a few descriptors. Each of those is checked against the capacity rule. The 16-bit address space lets a 4 KiB word array stand in for memory, holding both descriptor rings and data buffers. Reads return after two cycles, and unaligned buffer addresses exercise the byte-lane selection.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int DESC_STRIDE = 16;
  localparam int OWN_BIT     = 31;
  localparam int LAST_BIT    = 29;
  localparam int WRAP_BIT    = 21;
  localparam int LEN_W       = 12;
  localparam int BUF1_LIMIT  = 2048;

  // strobes from control to datapath
  typedef struct packed {
    logic rdSelData;
    logic clrWord;
    logic capWord;
    logic clrByte;
    logic latchByte;
    logic commitSeg;
    logic dropSet;
    logic wrBack;
    logic advPtr;
    logic clrFrame;
    logic emitByte;
  } txd_strb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic own;
    logic lastSeg;
    logic wordLast;
    logic segDone;
    logic overflow;
    logic dropping;
    logic emitDone;
    logic sizeBad;
  } txd_stat_t;

endpackage

// File: rtl/txd_dpath.sv
module txd_dpath
  import txd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int FRAME_BYTES = 256
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baseWr,
  input  logic [AW-1:0] baseIn,
  input  txd_strb_t     strb,
  input  logic [31:0]   memRdData,
  output txd_stat_t     stat,
  output logic [AW-1:0] memRdAddr,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [31:0]   memWrData,
  output logic [7:0]    txData,
  output logic          txValid,
  output logic          txLast,
  output logic [AW-1:0] curPtrOut
);

  localparam int FI_W  = $clog2(FRAME_BYTES);
  localparam int FL_W  = FI_W + 1;
  localparam int SEG_W = LEN_W + 1;
  localparam int SUM_W = ((FL_W > SEG_W) ? FL_W : SEG_W) + 1;

  logic [AW-1:0]    basePtr, curPtr;
  logic [31:0]      ctlWord;
  logic [LEN_W-1:0] size1, size2;
  logic [AW-1:0]    bufAddr;
  logic [1:0]       wordIdx;
  logic [SEG_W-1:0] byteIdx;
  logic [FL_W-1:0]  frameLen, emitIdx;
  logic             dropping;
  logic [7:0]       frameMem [FRAME_BYTES];

  logic [SEG_W-1:0] segLen;
  logic [SUM_W-1:0] sumLen;
  logic [AW-1:0]    byteAddr;
  logic [1:0]       lane;
  logic [7:0]       rdByte;
  logic [FI_W-1:0]  wrIdx;
  logic [31:0]      shifted;

  assign segLen   = {1'b0, size1} + {1'b0, size2};
  assign sumLen   = SUM_W'(frameLen) + SUM_W'(segLen);
  assign byteAddr = bufAddr + AW'(byteIdx);
  assign lane     = byteAddr[1:0];
  assign shifted  = memRdData >> {lane, 3'b000};
  assign rdByte   = shifted[7:0];
  assign wrIdx    = FI_W'(frameLen) + FI_W'(byteIdx);

  assign stat.own      = ctlWord[OWN_BIT];
  assign stat.lastSeg  = ctlWord[LAST_BIT];
  assign stat.wordLast = (wordIdx == 2'd3);
  assign stat.segDone  = (byteIdx == segLen);
  assign stat.overflow = (sumLen >= SUM_W'(FRAME_BYTES));
  assign stat.dropping = dropping;
  assign stat.emitDone = (emitIdx == frameLen);
  assign stat.sizeBad  = (size1 > LEN_W'(BUF1_LIMIT)) || (size2 != '0);

  assign memRdAddr = strb.rdSelData ? {byteAddr[AW-1:2], 2'b00}
                                    : curPtr + AW'({wordIdx, 2'b00});
  assign memWrEn   = strb.wrBack;
  assign memWrAddr = curPtr;
  assign memWrData = ctlWord & ~(32'h1 << OWN_BIT);
  assign curPtrOut = curPtr;

  // ring pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
      curPtr  <= '0;
    end else if (baseWr) begin
      basePtr <= baseIn;
      curPtr  <= baseIn;
    end else if (strb.advPtr) begin
      curPtr <= ctlWord[WRAP_BIT] ? basePtr : curPtr + AW'(DESC_STRIDE);
    end
  end

  // descriptor capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlWord <= '0;
      size1   <= '0;
      size2   <= '0;
      bufAddr <= '0;
      wordIdx <= '0;
    end else if (strb.clrWord) begin
      wordIdx <= '0;
    end else if (strb.capWord) begin
      case (wordIdx)
        2'd0: ctlWord <= memRdData;
        2'd1: begin
          size1 <= memRdData[LEN_W-1:0];
          size2 <= memRdData[16 +: LEN_W];
        end
        2'd2: bufAddr <= memRdData[AW-1:0];
        default: ;
      endcase
      wordIdx <= wordIdx + 2'd1;
    end
  end

  // segment and frame accounting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx  <= '0;
      frameLen <= '0;
      emitIdx  <= '0;
      dropping <= 1'b0;
    end else begin
      if (strb.clrByte)        byteIdx <= '0;
      else if (strb.latchByte) byteIdx <= byteIdx + SEG_W'(1);
      if (strb.clrFrame) begin
        frameLen <= '0;
        emitIdx  <= '0;
        dropping <= 1'b0;
      end else begin
        if (strb.commitSeg) frameLen <= FL_W'(sumLen);
        if (strb.dropSet)   dropping <= 1'b1;
        if (strb.emitByte)  emitIdx  <= emitIdx + FL_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.latchByte) frameMem[wrIdx] <= rdByte;
  end

  // output stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txLast  <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strb.emitByte;
      txLast  <= strb.emitByte && ((emitIdx + FL_W'(1)) == frameLen);
      txData  <= frameMem[emitIdx[FI_W-1:0]];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchByte |-> (SUM_W'(frameLen) + SUM_W'(byteIdx)) < SUM_W'(FRAME_BYTES)); // R9

  AST_EMIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitByte |-> (emitIdx < frameLen)); // R5

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      pollDemand,
  input  logic      memRdValid,
  input  txd_stat_t stat,
  output txd_strb_t strb,
  output logic      memRdReq,
  output logic      txDonePulse,
  output logic      summaryPulse,
  output logic      sizeErrPulse,
  output logic      dropErrPulse
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_CHECK, S_BYTE_CHK,
    S_BYTE_REQ, S_BYTE_WAIT, S_WRBACK, S_EMIT, S_NEXT
  } state_t;

  state_t state, nextState;
  logic   doneSet, sizeSet, dropSet;

  always_comb begin
    strb      = '0;
    memRdReq  = 1'b0;
    nextState = state;
    doneSet   = 1'b0;
    sizeSet   = 1'b0;
    dropSet   = 1'b0;
    case (state)
      S_IDLE: if (pollDemand && txEnable) begin
        strb.clrWord = 1'b1;
        nextState    = S_RD_REQ;
      end
      S_RD_REQ: begin
        memRdReq  = 1'b1;
        nextState = S_RD_WAIT;
      end
      S_RD_WAIT: if (memRdValid) begin
        strb.capWord = 1'b1;
        nextState    = stat.wordLast ? S_CHECK : S_RD_REQ;
      end
      S_CHECK: begin
        if (!stat.own) begin
          nextState = S_IDLE;
        end else begin
          sizeSet = stat.sizeBad;
          if (stat.dropping || stat.overflow) begin
            strb.dropSet = 1'b1;
            dropSet      = !stat.dropping;
            nextState    = S_WRBACK;
          end else begin
            strb.clrByte = 1'b1;
            nextState    = S_BYTE_CHK;
          end
        end
      end
      S_BYTE_CHK: begin
        if (stat.segDone) begin
          strb.commitSeg = 1'b1;
          nextState      = S_WRBACK;
        end else begin
          nextState = S_BYTE_REQ;
        end
      end
      S_BYTE_REQ: begin
        strb.rdSelData = 1'b1;
        memRdReq       = 1'b1;
        nextState      = S_BYTE_WAIT;
      end
      S_BYTE_WAIT: begin
        strb.rdSelData = 1'b1;
        if (memRdValid) begin
          strb.latchByte = 1'b1;
          nextState      = S_BYTE_CHK;
        end
      end
      S_WRBACK: begin
        strb.wrBack = 1'b1;
        strb.advPtr = 1'b1;
        if (!stat.lastSeg) begin
          nextState = S_NEXT;
        end else if (stat.dropping) begin
          strb.clrFrame = 1'b1;
          nextState     = S_NEXT;
        end else begin
          nextState = S_EMIT;
        end
      end
      S_EMIT: begin
        if (stat.emitDone) begin
          doneSet       = 1'b1;
          strb.clrFrame = 1'b1;
          nextState     = S_NEXT;
        end else begin
          strb.emitByte = 1'b1;
        end
      end
      S_NEXT: begin
        if (txEnable) begin
          strb.clrWord = 1'b1;
          nextState    = S_RD_REQ;
        end else begin
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      txDonePulse  <= 1'b0;
      summaryPulse <= 1'b0;
      sizeErrPulse <= 1'b0;
      dropErrPulse <= 1'b0;
    end else begin
      state        <= nextState;
      txDonePulse  <= doneSet;
      summaryPulse <= doneSet;
      sizeErrPulse <= sizeSet;
      dropErrPulse <= dropSet;
    end
  end

  AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBack |-> stat.own); // R6

  AST_NO_BYTE_PAST_SEG: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchByte |-> !stat.segDone); // R4

  AST_DONE_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    doneSet |-> !stat.dropping); // R9

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int FRAME_BYTES = 256
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txEnable,
  input  logic          pollDemand,
  input  logic          ringBaseWr,
  input  logic [AW-1:0] ringBase,
  output logic [AW-1:0] curDescAddr,
  output logic          memRdReq,
  output logic [AW-1:0] memRdAddr,
  input  logic          memRdValid,
  input  logic [31:0]   memRdData,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [31:0]   memWrData,
  output logic [7:0]    txData,
  output logic          txValid,
  output logic          txLast,
  output logic          txDonePulse,
  output logic          summaryPulse,
  output logic          sizeErrPulse,
  output logic          dropErrPulse
);

  txd_strb_t strb;
  txd_stat_t stat;

  txd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txEnable     (txEnable),
    .pollDemand   (pollDemand),
    .memRdValid   (memRdValid),
    .stat         (stat),
    .strb         (strb),
    .memRdReq     (memRdReq),
    .txDonePulse  (txDonePulse),
    .summaryPulse (summaryPulse),
    .sizeErrPulse (sizeErrPulse),
    .dropErrPulse (dropErrPulse)
  );

  txd_dpath #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .baseWr    (ringBaseWr),
    .baseIn    (ringBase),
    .strb      (strb),
    .memRdData (memRdData),
    .stat      (stat),
    .memRdAddr (memRdAddr),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .txData    (txData),
    .txValid   (txValid),
    .txLast    (txLast),
    .curPtrOut (curDescAddr)
  );

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !memRdReq); // R6

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R5

endmodule

// File: tb/sim_txd_ring_engine.sv
module sim_txd_ring_engine;

  localparam int AW = 16;
  localparam int FB = 64;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h2000_0000;
  localparam logic [31:0] WRAP = 32'h0020_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, pollDemand = 1'b0, ringBaseWr = 1'b0;
  logic [AW-1:0] ringBase = '0;
  logic [AW-1:0] curDescAddr, memRdAddr, memWrAddr;
  logic memRdReq, memWrEn, txValid, txLast;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = '0, memWrData;
  logic [7:0] txData;
  logic txDonePulse, summaryPulse, sizeErrPulse, dropErrPulse;

  always #2 clk = ~clk;

  txd_ring_engine #(.AW(AW), .FRAME_BYTES(FB)) u0 (.*);

  logic [31:0] mem [1024];
  logic hostWrEn = 1'b0;
  logic [AW-1:0] hostWrAddr = '0;
  logic [31:0] hostWrData = '0;
  logic p1 = 1'b0;
  logic [AW-1:0] a1 = '0;
  int rdCnt = 0, wrCnt = 0, rxCnt = 0, lastCnt = 0;
  int doneCnt = 0, sumCnt = 0, sizeCnt = 0, dropCnt = 0;
  logic [7:0] rxBytes [1024];
  int checks = 0, fails = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    p1 <= memRdReq;
    a1 <= memRdAddr;
    memRdValid <= p1;
    memRdData <= mem[a1[11:2]];
    if (!rstN) begin
      for (int i = 0; i < 1024; i++)
        mem[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    end else if (hostWrEn) mem[hostWrAddr[11:2]] <= hostWrData;
    else if (memWrEn) mem[memWrAddr[11:2]] <= memWrData;
    if (rstN) begin
      if (memRdReq) rdCnt <= rdCnt + 1;
      if (memWrEn) wrCnt <= wrCnt + 1;
      if (txValid) begin rxBytes[rxCnt] <= txData; rxCnt <= rxCnt + 1; end
      if (txLast) lastCnt <= lastCnt + 1;
      if (txDonePulse) doneCnt <= doneCnt + 1;
      if (summaryPulse) sumCnt <= sumCnt + 1;
      if (sizeErrPulse) sizeCnt <= sizeCnt + 1;
      if (dropErrPulse) dropCnt <= dropCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic putWord(input int addr, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrAddr = AW'(addr); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic putDesc(input int addr, input logic [31:0] ctl, input int s1, input int s2, input int ba);
    putWord(addr, ctl);
    putWord(addr + 4, {4'h0, 12'(s2), 4'h0, 12'(s1)});
    putWord(addr + 8, 32'(ba));
    putWord(addr + 12, 32'h0);
  endtask

  task automatic loadBase(input int b);
    @(negedge clk); ringBase = AW'(b); ringBaseWr = 1'b1;
    @(negedge clk); ringBaseWr = 1'b0;
  endtask

  task automatic poll();
    @(negedge clk); pollDemand = 1'b1;
    @(negedge clk); pollDemand = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBytes(input string req, input int start, input int base, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (rxBytes[start + k] !== pat(base + k)) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic testReset();
    check(curDescAddr == 0, "R1 pointer", int'(curDescAddr), 0);
    check(!memRdReq && !memWrEn && !txValid, "R1 quiet", {memRdReq, memWrEn, txValid}, 0);
  endtask

  task automatic testDisabledPoll();
    int r0 = rdCnt;
    txEnable = 1'b0;
    loadBase(32'h100);
    poll();
    idle(50);
    check(rdCnt == r0, "R2 disabled poll ignored", rdCnt - r0, 0);
    check(curDescAddr == 16'h100, "R11 base load", int'(curDescAddr), 32'h100);
  endtask

  task automatic testSingle();
    int r0 = rdCnt, w0 = wrCnt, x0 = rxCnt, l0 = lastCnt, d0 = doneCnt, s0 = sumCnt;
    putDesc(32'h100, OWN | LAST | 32'h0000_1234, 10, 0, 32'h403);
    putWord(32'h110, 32'h0);
    txEnable = 1'b1;
    poll();
    idle(600);
    check(rdCnt - r0 == 18, "R2 R4 read count", rdCnt - r0, 18);
    check(rxCnt - x0 == 10, "R4 byte count", rxCnt - x0, 10);
    checkBytes("R4 unaligned bytes", x0, 32'h403, 10);
    check(lastCnt - l0 == 1, "R5 one txLast", lastCnt - l0, 1);
    check(doneCnt - d0 == 1 && sumCnt - s0 == 1, "R5 pulses", doneCnt - d0, 1);
    check(mem[32'h100 >> 2] == (LAST | 32'h1234), "R6 writeback", int'(mem[32'h100 >> 2]), int'(LAST | 32'h1234));
    check(wrCnt - w0 == 1, "R3 no writeback of unowned", wrCnt - w0, 1);
    check(curDescAddr == 16'h110, "R7 R3 pointer advance", int'(curDescAddr), 32'h110);
  endtask

  task automatic testWrapMulti();
    int r0 = rdCnt, x0 = rxCnt, d0 = doneCnt, z0 = sizeCnt;
    txEnable = 1'b0;
    loadBase(32'h200);
    putDesc(32'h200, OWN, 5, 0, 32'h500);
    putDesc(32'h210, OWN | LAST | WRAP, 3, 2, 32'h600);
    txEnable = 1'b1;
    poll();
    idle(600);
    check(rdCnt - r0 == 22, "R2 wrap read count", rdCnt - r0, 22);
    check(rxCnt - x0 == 10, "R5 accumulated length", rxCnt - x0, 10);
    checkBytes("R5 first segment", x0, 32'h500, 5);
    checkBytes("R4 second segment", x0 + 5, 32'h600, 5);
    check(doneCnt - d0 == 1, "R5 one frame", doneCnt - d0, 1);
    check(sizeCnt - z0 == 1, "R8 buffer2 nonzero", sizeCnt - z0, 1);
    check(curDescAddr == 16'h200, "R7 wrap to base", int'(curDescAddr), 32'h200);
  endtask

  task automatic testCapacity();
    int x0 = rxCnt, d0 = doneCnt, p0 = dropCnt, z0 = sizeCnt, l0 = lastCnt;
    txEnable = 1'b0;
    loadBase(32'h300);
    putDesc(32'h300, OWN, 40, 0, 32'h700);
    putDesc(32'h310, OWN | LAST, 30, 0, 32'h700);
    putDesc(32'h320, OWN | LAST, 63, 0, 32'h700);
    putDesc(32'h330, OWN | LAST, 64, 0, 32'h700);
    putDesc(32'h340, OWN | LAST, 32'h900, 0, 32'h700);
    putWord(32'h350, 32'h0);
    txEnable = 1'b1;
    poll();
    idle(3000);
    check(dropCnt - p0 == 3, "R9 drop count", dropCnt - p0, 3);
    check(rxCnt - x0 == 63, "R9 63-byte frame sent", rxCnt - x0, 63);
    checkBytes("R9 63-byte content", x0, 32'h700, 63);
    check(doneCnt - d0 == 1 && lastCnt - l0 == 1, "R9 one completion", doneCnt - d0, 1);
    check(sizeCnt - z0 == 1, "R8 buffer1 above limit", sizeCnt - z0, 1);
    check(mem[32'h310 >> 2] == LAST, "R6 dropped still written", int'(mem[32'h310 >> 2]), int'(LAST));
    check(curDescAddr == 16'h350, "R10 walk continues", int'(curDescAddr), 32'h350);
  endtask

  task automatic testDisableMidWalk();
    int x0 = rxCnt, d0 = doneCnt;
    txEnable = 1'b0;
    loadBase(32'h3a0);
    putDesc(32'h3a0, OWN | LAST, 4, 0, 32'h780);
    putDesc(32'h3b0, OWN | LAST, 4, 0, 32'h790);
    txEnable = 1'b1;
    poll();
    idle(3);
    txEnable = 1'b0;
    idle(400);
    check(doneCnt - d0 == 1 && rxCnt - x0 == 4, "R10 one frame then stop", doneCnt - d0, 1);
    check(curDescAddr == 16'h3b0, "R10 pointer", int'(curDescAddr), 32'h3b0);
    check(mem[32'h3b0 >> 2] == (OWN | LAST), "R10 next untouched", int'(mem[32'h3b0 >> 2]), int'(OWN | LAST));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    testReset();
    testDisabledPoll();
    testSingle();
    testWrapMulti();
    testCapacity();
    testDisableMidWalk();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule